// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the register-level control plane of a multi-channel DMA engine that supports up to 64 channels. Every per-channel flag is held in a 64-bit vector and read back as two 32-bit words: a high word for channels 63..32 and a low word for channels 31..0. The flags are hardware-request enable, error-interrupt enable, interrupt pending, error pending, done and sampled hardware request. Software changes single flags by writing a channel number into a byte-wide command slot. This avoids read-modify-write races between channels. The interrupt and error words also accept write-one-to-clear, so many channels can be acknowledged in one access.

The transfer engines report completion, error and done events on per-channel input vectors. The block turns these into pending flags, a single interrupt line and a global error status word. The status word keeps the first failure: the lowest failing channel number and the cause flags. The block also drives the request-enable vector, one-cycle start pulses and the three arbitration and clocking control bits that the rest of the engine consumes.

Top module: `dmacr_regfile`

## Requirements
- R1: After synchronous reset, every readable word reads 0, and `req_en_o`, `start_o`, `irq_o` and the control outputs are 0.
- R2: A byte written at offset 0x18 sets the request-enable flag of the channel it names. A byte written at 0x19 clears that flag. Offsets 0x08 and 0x0C hold the high and low request-enable words, and they can be written with byte strobes. `req_en_o` shows the new value in the cycle after the write. If one write both sets and clears the same channel, the set wins.
- R3: A byte at 0x1A sets, and a byte at 0x1B clears, the error-interrupt enable of the named channel. The enable words read back at 0x10 (high) and 0x14 (low).
- R4: A byte at 0x1E produces a one-cycle pulse on `start_o[ch]` in the cycle after the write.
- R5: An `int_evt_i` event sets the interrupt-pending flag of its channel, and an `err_evt_i` event sets the error-pending flag. A byte at 0x1C clears the named interrupt-pending flag, and a byte at 0x1D clears the named error-pending flag. An event in the same cycle as a clear keeps the flag set.
- R6: The interrupt words (0x20 high, 0x24 low) and the error words (0x28 high, 0x2C low) clear every bit written as 1. Bit i of a high word belongs to channel 32+i.
- R7: `irq_o` is the OR of all interrupt-pending flags and of every error-pending flag whose error-interrupt enable is set. It is registered, so it follows the flags by one cycle.
- R8: Error status at 0x04 has this layout: bit 31 is the valid flag, bits 13:8 hold the lowest channel that raised an error, and bits 15:14 and 7:0 copy `err_cause_i`. All other bits are 0. The word is captured only while the valid flag is clear. Any clear-error command (0x1D) zeroes it, and an error arriving in that same cycle is captured. A write-one-to-clear on the error words leaves the status word unchanged.
- R9: A command byte whose value is at or above `NUM_CH` changes nothing. This covers flags, pulses and the status word.
- R10: A `done_evt_i` event sets the channel's done flag. The done flags read at 0x38 (high) and 0x3C (low), and a byte at 0x1F clears the named one.
- R11: The control word at 0x00 keeps only bits 31 (dynamic clock), 3 (round-robin group) and 2 (round-robin channel). The other bits read 0. The word obeys byte strobes and drives `dyn_clk_o`, `rr_grp_o` and `rr_ch_o`.
- R12: Read data appears on `rd_data_o` in the cycle after `rd_en_i` and holds until the next read. Offsets 0x30 and 0x34 return `hreq_i` as sampled one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Word-aligned write offset |
| wr_data_i | input | 32 | Write data; byte k is offset+k |
| wr_strb_i | input | 4 | Byte enables |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Word-aligned read offset |
| rd_data_o | output | 32 | Registered read data |
| int_evt_i | input | NUM_CH | Per-channel completion events |
| err_evt_i | input | NUM_CH | Per-channel error events |
| err_cause_i | input | 16 | Cause flags accompanying an error event |
| done_evt_i | input | NUM_CH | Per-channel done events |
| hreq_i | input | NUM_CH | Raw hardware request lines |
| req_en_o | output | NUM_CH | Hardware-request enable per channel |
| start_o | output | NUM_CH | One-cycle software start pulses |
| irq_o | output | 1 | Combined interrupt |
| dyn_clk_o | output | 1 | Dynamic clock enable |
| rr_grp_o | output | 1 | Round-robin group arbitration |
| rr_ch_o | output | 1 | Round-robin channel arbitration |

## Verification
A write changes its flag on the next edge. `req_en_o`, `start_o` and the control outputs reflect it at the following falling edge. `irq_o` has one more register in its path, so it trails an event or a clear by two edges. Read data, and the sampled request lines behind it, are valid one edge after the read strobe. The bench drives inputs on falling edges and updates its behavioural model on the same rising edges as the design. It compares every output on every falling edge, which keeps each result aligned to the cycle in which it becomes due. The directed reads wait one further falling edge before checking a flag that an event has just set.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
  localparam int REG_W   = 32;
  localparam int STRB_W  = REG_W / 8;
  localparam int VEC_W   = 2 * REG_W;
  localparam int NUM_CMD = 8;

  localparam logic [7:0] OFF_CTRL    = 8'h00;
  localparam logic [7:0] OFF_ESTAT   = 8'h04;
  localparam logic [7:0] OFF_REQ_HI  = 8'h08;
  localparam logic [7:0] OFF_REQ_LO  = 8'h0C;
  localparam logic [7:0] OFF_EIE_HI  = 8'h10;
  localparam logic [7:0] OFF_EIE_LO  = 8'h14;
  localparam logic [7:0] OFF_CMD_A   = 8'h18;
  localparam logic [7:0] OFF_CMD_B   = 8'h1C;
  localparam logic [7:0] OFF_INT_HI  = 8'h20;
  localparam logic [7:0] OFF_INT_LO  = 8'h24;
  localparam logic [7:0] OFF_ERR_HI  = 8'h28;
  localparam logic [7:0] OFF_ERR_LO  = 8'h2C;
  localparam logic [7:0] OFF_HRS_HI  = 8'h30;
  localparam logic [7:0] OFF_HRS_LO  = 8'h34;
  localparam logic [7:0] OFF_DONE_HI = 8'h38;
  localparam logic [7:0] OFF_DONE_LO = 8'h3C;

  localparam logic [REG_W-1:0] CTRL_KEEP = 32'h8000_000C;

  // Command slot index = byte offset - 0x18
  typedef enum logic [2:0] {
    CMD_SET_REQ   = 3'd0,
    CMD_CLR_REQ   = 3'd1,
    CMD_SET_EIE   = 3'd2,
    CMD_CLR_EIE   = 3'd3,
    CMD_CLR_INT   = 3'd4,
    CMD_CLR_ERR   = 3'd5,
    CMD_SET_START = 3'd6,
    CMD_CLR_DONE  = 3'd7
  } cmd_e;
endpackage

// File: rtl/dmacr_cmd_decode.sv
module dmacr_cmd_decode
  import dmacr_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int ADDR_W = 8
) (
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [REG_W-1:0]                wr_data_i,
  input  logic [STRB_W-1:0]               wr_strb_i,
  output logic [NUM_CMD-1:0][NUM_CH-1:0]  hit_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(OFF_CMD_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(OFF_CMD_B);

  for (genvar k = 0; k < NUM_CMD; k++) begin : g_slot
    localparam int LANE = k % STRB_W;
    localparam logic [ADDR_W-1:0] SLOT_ADDR = (k < STRB_W) ? ADDR_A : ADDR_B;
    logic              sel;
    logic [7:0]        chn;
    logic [NUM_CH-1:0] oh;

    assign sel = wr_en_i && (wr_addr_i == SLOT_ADDR) && wr_strb_i[LANE];
    assign chn = wr_data_i[8*LANE +: 8];

    always_comb begin
      oh = '0;
      if (sel && (int'(chn) < NUM_CH)) oh[chn[CH_W-1:0]] = 1'b1;
    end

    assign hit_o[k] = oh;
  end
endmodule

// File: rtl/dmacr_flag_vec.sv
module dmacr_flag_vec #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] ld_mask_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] merged;

  assign merged = (q_o & ~ld_mask_i) | (ld_val_i & ld_mask_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= (merged & ~clr_i) | set_i;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i))); // R5

  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0)); // R5
endmodule

// File: rtl/dmacr_err_capture.sv
module dmacr_err_capture
  import dmacr_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] err_evt_i,
  input  logic [15:0]       cause_i,
  input  logic              clr_i,
  output logic [REG_W-1:0]  status_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [CH_W-1:0] low_idx;
  logic            held;

  always_comb begin
    low_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (err_evt_i[i]) low_idx = CH_W'(i);
    end
  end

  assign held = status_o[31] && !clr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
    end else if (!held && (|err_evt_i)) begin
      status_o <= {1'b1, 15'b0, cause_i[15:14], 6'(low_idx), cause_i[7:0]};
    end else if (clr_i) begin
      status_o <= '0;
    end
  end

  AST_FIRST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
    (status_o[31] && !clr_i) |=> $stable(status_o)); // R8

  AST_ERR_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    ((|err_evt_i) && !status_o[31]) |=> status_o[31]); // R8
endmodule

// File: rtl/dmacr_regfile.sv
module dmacr_regfile
  import dmacr_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [3:0]        wr_strb_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic [NUM_CH-1:0] int_evt_i,
  input  logic [NUM_CH-1:0] err_evt_i,
  input  logic [15:0]       err_cause_i,
  input  logic [NUM_CH-1:0] done_evt_i,
  input  logic [NUM_CH-1:0] hreq_i,
  output logic [NUM_CH-1:0] req_en_o,
  output logic [NUM_CH-1:0] start_o,
  output logic              irq_o,
  output logic              dyn_clk_o,
  output logic              rr_grp_o,
  output logic              rr_ch_o
);
  logic [NUM_CMD-1:0][NUM_CH-1:0] cmd_hit;
  logic [REG_W-1:0]  bmask;
  logic [NUM_CH-1:0] ld_val, req_m, eie_m, int_w1c, err_w1c, zero_v;
  logic [NUM_CH-1:0] req_q, eie_q, int_q, err_q, done_q, hrs_q, start_q;
  logic [REG_W-1:0]  ctrl_q, estat, rd_q, rd_nxt;
  logic              irq_q;
  logic [VEC_W-1:0]  req_w, eie_w, int_w, err_w, done_w, hrs_w;

  function automatic logic [VEC_W-1:0] widen(input logic [NUM_CH-1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    r[NUM_CH-1:0] = v;
    return r;
  endfunction

  function automatic logic [NUM_CH-1:0] pair(input logic hi, input logic lo,
                                             input logic [REG_W-1:0] m);
    logic [VEC_W-1:0] r;
    r = {(hi ? m : {REG_W{1'b0}}), (lo ? m : {REG_W{1'b0}})};
    return r[NUM_CH-1:0];
  endfunction

  function automatic logic wr_at(input logic en, input logic [ADDR_W-1:0] a,
                                 input logic [7:0] off);
    return en && (a == ADDR_W'(off));
  endfunction

  always_comb begin
    for (int b = 0; b < STRB_W; b++) bmask[8*b +: 8] = {8{wr_strb_i[b]}};
  end

  assign zero_v  = '0;
  assign ld_val  = pair(1'b1, 1'b1, wr_data_i);
  assign req_m   = pair(wr_at(wr_en_i, wr_addr_i, OFF_REQ_HI),
                        wr_at(wr_en_i, wr_addr_i, OFF_REQ_LO), bmask);
  assign eie_m   = pair(wr_at(wr_en_i, wr_addr_i, OFF_EIE_HI),
                        wr_at(wr_en_i, wr_addr_i, OFF_EIE_LO), bmask);
  assign int_w1c = pair(wr_at(wr_en_i, wr_addr_i, OFF_INT_HI),
                        wr_at(wr_en_i, wr_addr_i, OFF_INT_LO), bmask & wr_data_i);
  assign err_w1c = pair(wr_at(wr_en_i, wr_addr_i, OFF_ERR_HI),
                        wr_at(wr_en_i, wr_addr_i, OFF_ERR_LO), bmask & wr_data_i);

  dmacr_cmd_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_cmd (
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .wr_strb_i(wr_strb_i), .hit_o(cmd_hit));

  dmacr_flag_vec #(.W(NUM_CH)) u_req (
    .clk(clk), .rst(rst), .set_i(cmd_hit[CMD_SET_REQ]), .clr_i(cmd_hit[CMD_CLR_REQ]),
    .ld_mask_i(req_m), .ld_val_i(ld_val), .q_o(req_q));

  dmacr_flag_vec #(.W(NUM_CH)) u_eie (
    .clk(clk), .rst(rst), .set_i(cmd_hit[CMD_SET_EIE]), .clr_i(cmd_hit[CMD_CLR_EIE]),
    .ld_mask_i(eie_m), .ld_val_i(ld_val), .q_o(eie_q));

  dmacr_flag_vec #(.W(NUM_CH)) u_int (
    .clk(clk), .rst(rst), .set_i(int_evt_i), .clr_i(cmd_hit[CMD_CLR_INT] | int_w1c),
    .ld_mask_i(zero_v), .ld_val_i(zero_v), .q_o(int_q));

  dmacr_flag_vec #(.W(NUM_CH)) u_err (
    .clk(clk), .rst(rst), .set_i(err_evt_i), .clr_i(cmd_hit[CMD_CLR_ERR] | err_w1c),
    .ld_mask_i(zero_v), .ld_val_i(zero_v), .q_o(err_q));

  dmacr_flag_vec #(.W(NUM_CH)) u_done (
    .clk(clk), .rst(rst), .set_i(done_evt_i), .clr_i(cmd_hit[CMD_CLR_DONE]),
    .ld_mask_i(zero_v), .ld_val_i(zero_v), .q_o(done_q));

  dmacr_err_capture #(.NUM_CH(NUM_CH)) u_estat (
    .clk(clk), .rst(rst), .err_evt_i(err_evt_i), .cause_i(err_cause_i),
    .clr_i(|cmd_hit[CMD_CLR_ERR]), .status_o(estat));

  always_ff @(posedge clk) begin
    if (rst) begin
      hrs_q   <= '0;
      start_q <= '0;
      irq_q   <= 1'b0;
      ctrl_q  <= '0;
    end else begin
      hrs_q   <= hreq_i;
      start_q <= cmd_hit[CMD_SET_START];
      irq_q   <= (|int_q) || (|(err_q & eie_q));
      if (wr_at(wr_en_i, wr_addr_i, OFF_CTRL))
        ctrl_q <= ((ctrl_q & ~bmask) | (wr_data_i & bmask)) & CTRL_KEEP;
    end
  end

  assign req_w  = widen(req_q);
  assign eie_w  = widen(eie_q);
  assign int_w  = widen(int_q);
  assign err_w  = widen(err_q);
  assign done_w = widen(done_q);
  assign hrs_w  = widen(hrs_q);

  always_comb begin
    rd_nxt = '0;
    case (rd_addr_i)
      ADDR_W'(OFF_CTRL):    rd_nxt = ctrl_q;
      ADDR_W'(OFF_ESTAT):   rd_nxt = estat;
      ADDR_W'(OFF_REQ_HI):  rd_nxt = req_w[VEC_W-1:REG_W];
      ADDR_W'(OFF_REQ_LO):  rd_nxt = req_w[REG_W-1:0];
      ADDR_W'(OFF_EIE_HI):  rd_nxt = eie_w[VEC_W-1:REG_W];
      ADDR_W'(OFF_EIE_LO):  rd_nxt = eie_w[REG_W-1:0];
      ADDR_W'(OFF_INT_HI):  rd_nxt = int_w[VEC_W-1:REG_W];
      ADDR_W'(OFF_INT_LO):  rd_nxt = int_w[REG_W-1:0];
      ADDR_W'(OFF_ERR_HI):  rd_nxt = err_w[VEC_W-1:REG_W];
      ADDR_W'(OFF_ERR_LO):  rd_nxt = err_w[REG_W-1:0];
      ADDR_W'(OFF_HRS_HI):  rd_nxt = hrs_w[VEC_W-1:REG_W];
      ADDR_W'(OFF_HRS_LO):  rd_nxt = hrs_w[REG_W-1:0];
      ADDR_W'(OFF_DONE_HI): rd_nxt = done_w[VEC_W-1:REG_W];
      ADDR_W'(OFF_DONE_LO): rd_nxt = done_w[REG_W-1:0];
      default:              rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_nxt;
  end

  assign rd_data_o = rd_q;
  assign req_en_o  = req_q;
  assign start_o   = start_q;
  assign irq_o     = irq_q;
  assign dyn_clk_o = ctrl_q[31];
  assign rr_grp_o  = ctrl_q[3];
  assign rr_ch_o   = ctrl_q[2];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(req_en_o)); // R2

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (|start_o) |-> $past(wr_en_i)); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o)); // R12

  AST_CTRL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable({dyn_clk_o, rr_grp_o, rr_ch_o})); // R11
endmodule

// File: tb/dmacr_regfile_tb.sv
module dmacr_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64;
  localparam int WD_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = '0;
  logic [15:0] err_cause = '0;
  logic [NCH-1:0] int_evt = '0, err_evt = '0, done_evt = '0, hreq = '0;
  logic [31:0] rd_data_o;
  logic [NCH-1:0] req_en_o, start_o;
  logic irq_o, dyn_clk_o, rr_grp_o, rr_ch_o;

  int n_chk = 0, n_fail = 0;
  bit chk_on = 1'b0, finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmacr_regfile #(.NUM_CH(NCH), .ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_strb_i(wr_strb), .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data_o),
    .int_evt_i(int_evt), .err_evt_i(err_evt), .err_cause_i(err_cause),
    .done_evt_i(done_evt), .hreq_i(hreq), .req_en_o(req_en_o), .start_o(start_o),
    .irq_o(irq_o), .dyn_clk_o(dyn_clk_o), .rr_grp_o(rr_grp_o), .rr_ch_o(rr_ch_o));

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_req, m_eie, m_int, m_err, m_done, m_hrs, m_start;
  logic [31:0] m_ctrl, m_es, m_rd;
  logic        m_irq;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;        8'h04: return m_es;
      8'h08: return m_req[63:32];  8'h0C: return m_req[31:0];
      8'h10: return m_eie[63:32];  8'h14: return m_eie[31:0];
      8'h20: return m_int[63:32];  8'h24: return m_int[31:0];
      8'h28: return m_err[63:32];  8'h2C: return m_err[31:0];
      8'h30: return m_hrs[63:32];  8'h34: return m_hrs[31:0];
      8'h38: return m_done[63:32]; 8'h3C: return m_done[31:0];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [63:0] c [8];
    logic [63:0] n_req, n_eie, w1c_i, w1c_e;
    logic [31:0] bm;
    int low;
    if (rst) begin
      m_req <= '0; m_eie <= '0; m_int <= '0; m_err <= '0; m_done <= '0;
      m_hrs <= '0; m_start <= '0; m_ctrl <= '0; m_es <= '0; m_rd <= '0; m_irq <= 1'b0;
    end else begin
      bm = {{8{wr_strb[3]}}, {8{wr_strb[2]}}, {8{wr_strb[1]}}, {8{wr_strb[0]}}};
      for (int k = 0; k < 8; k++) c[k] = '0;
      if (wr_en && (wr_addr == 8'h18 || wr_addr == 8'h1C)) begin
        for (int l = 0; l < 4; l++) begin
          automatic int ch = int'(wr_data[8*l +: 8]);
          automatic int k = l + ((wr_addr == 8'h1C) ? 4 : 0);
          if (wr_strb[l] && ch < NCH) c[k][ch] = 1'b1;
        end
      end
      n_req = m_req; n_eie = m_eie; w1c_i = '0; w1c_e = '0;
      if (wr_en) begin
        case (wr_addr)
          8'h08: n_req[63:32] = (m_req[63:32] & ~bm) | (wr_data & bm);
          8'h0C: n_req[31:0]  = (m_req[31:0] & ~bm) | (wr_data & bm);
          8'h10: n_eie[63:32] = (m_eie[63:32] & ~bm) | (wr_data & bm);
          8'h14: n_eie[31:0]  = (m_eie[31:0] & ~bm) | (wr_data & bm);
          8'h20: w1c_i[63:32] = wr_data & bm;
          8'h24: w1c_i[31:0]  = wr_data & bm;
          8'h28: w1c_e[63:32] = wr_data & bm;
          8'h2C: w1c_e[31:0]  = wr_data & bm;
          8'h00: m_ctrl <= ((m_ctrl & ~bm) | (wr_data & bm)) & 32'h8000_000C;
          default: ;
        endcase
      end
      m_req  <= (n_req & ~c[1]) | c[0];
      m_eie  <= (n_eie & ~c[3]) | c[2];
      m_int  <= (m_int & ~(c[4] | w1c_i)) | int_evt;
      m_err  <= (m_err & ~(c[5] | w1c_e)) | err_evt;
      m_done <= (m_done & ~c[7]) | done_evt;
      m_start <= c[6];
      m_hrs  <= hreq;
      m_irq  <= (m_int != 0) || ((m_err & m_eie) != 0);
      low = -1;
      for (int i = NCH - 1; i >= 0; i--) if (err_evt[i]) low = i;
      if ((!m_es[31] || c[5] != 0) && low >= 0)
        m_es <= 32'h8000_0000 | (32'(low) << 8) | {16'h0, err_cause & 16'hC0FF};
      else if (c[5] != 0)
        m_es <= '0;
      if (rd_en) m_rd <= m_read(rd_addr);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !rst) begin
      chk(req_en_o, m_req, "R2 req_en_o vs model");
      chk(start_o, m_start, "R4 start_o vs model");
      chk({63'b0, irq_o}, {63'b0, m_irq}, "R7 irq_o vs model");
      chk({32'b0, rd_data_o}, {32'b0, m_rd}, "R12 rd_data_o vs model");
      chk({61'b0, dyn_clk_o, rr_grp_o, rr_ch_o},
          {61'b0, m_ctrl[31], m_ctrl[3], m_ctrl[2]}, "R11 control outputs vs model");
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
    @(negedge clk); wr_en = 1'b0; wr_strb = '0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk({32'b0, rd_data_o}, {32'b0, exp}, tag);
  endtask

  // kind: 0 int, 1 err, 2 done
  task automatic pulse(input int kind, input logic [63:0] v, input logic [15:0] cause);
    @(negedge clk);
    case (kind)
      0: int_evt = v;
      1: begin err_evt = v; err_cause = cause; end
      default: done_evt = v;
    endcase
    @(negedge clk); int_evt = '0; err_evt = '0; done_evt = '0; err_cause = '0;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (5) @(negedge clk);
    rst = 1'b0; chk_on = 1'b1;
    // R1 reset state
    chk(req_en_o, 64'h0, "R1 req_en_o after reset");
    chk({63'b0, irq_o}, 64'h0, "R1 irq_o after reset");
    rd_chk(8'h04, 32'h0, "R1 error status after reset");
    rd_chk(8'h0C, 32'h0, "R1 request enable low after reset");
    rd_chk(8'h00, 32'h0, "R1 control after reset");
    // R2 set/clear request
    wr(8'h18, 32'h05, 4'b0001);
    chk(req_en_o, 64'h20, "R2 set ch5");
    wr(8'h18, 32'h28, 4'b0001);
    chk(req_en_o, (64'h1 << 40) | 64'h20, "R2 set ch40");
    rd_chk(8'h08, 32'h100, "R2 high word ch40");
    wr(8'h18, 32'h0500, 4'b0010);
    chk(req_en_o, 64'h1 << 40, "R2 clear ch5");
    wr(8'h18, 32'h0000_FF40, 4'b0011);
    chk(req_en_o, 64'h1 << 40, "R9 out-of-range channels ignored");
    wr(8'h0C, 32'hFFFF_FFA5, 4'b0001);
    chk(req_en_o, (64'h1 << 40) | 64'hA5, "R2 strobed word write");
    wr(8'h0C, 32'h0, 4'b1111);
    // R3
    wr(8'h18, 32'h0003_0000, 4'b0100);
    rd_chk(8'h14, 32'h8, "R3 set eie ch3");
    // R5 / R7 interrupt pending
    pulse(0, 64'h80, 16'h0);
    @(negedge clk);
    chk({63'b0, irq_o}, 64'h1, "R7 irq after int event");
    rd_chk(8'h24, 32'h80, "R5 int pending ch7");
    wr(8'h1C, 32'h07, 4'b0001);
    @(negedge clk);
    chk({63'b0, irq_o}, 64'h0, "R7 irq drops after clear");
    rd_chk(8'h24, 32'h0, "R5 clear int ch7");
    // R5 event wins over clear in same cycle
    @(negedge clk);
    int_evt = 64'h10; wr_en = 1'b1; wr_addr = 8'h1C; wr_data = 32'h04; wr_strb = 4'b0001;
    @(negedge clk);
    int_evt = '0; wr_en = 1'b0; wr_strb = '0;
    rd_chk(8'h24, 32'h10, "R5 event wins over clear");
    wr(8'h1C, 32'h04, 4'b0001);
    // R8 error status
    pulse(1, 64'h200, 16'hFFFF);
    rd_chk(8'h04, 32'h8000_C9FF, "R8 first error captured");
    pulse(1, (64'h1 << 50) | 64'h4, 16'h0001);
    rd_chk(8'h04, 32'h8000_C9FF, "R8 first error held");
    rd_chk(8'h2C, 32'h204, "R5 err pending low");
    rd_chk(8'h28, 32'h0004_0000, "R6 err pending high ch50");
    chk({63'b0, irq_o}, 64'h0, "R7 errors gated by eie");
    wr(8'h18, 32'h0002_0000, 4'b0100);
    @(negedge clk);
    chk({63'b0, irq_o}, 64'h1, "R7 enabled error raises irq");
    // R6 write-one-to-clear
    wr(8'h2C, 32'hFFFF_FFFF, 4'b1111);
    rd_chk(8'h2C, 32'h0, "R6 w1c low error word");
    rd_chk(8'h28, 32'h0004_0000, "R6 high word untouched");
    rd_chk(8'h04, 32'h8000_C9FF, "R8 status kept after w1c");
    wr(8'h1C, 32'h0000_4000, 4'b0010);
    rd_chk(8'h04, 32'h8000_C9FF, "R9 out-of-range clear-error ignored");
    wr(8'h1C, 32'h0000_3200, 4'b0010);
    rd_chk(8'h28, 32'h0, "R5 clear err ch50");
    rd_chk(8'h04, 32'h0, "R8 status cleared by command");
    // R4 start pulse
    wr(8'h1C, 32'h000C_0000, 4'b0100);
    chk(start_o, 64'h1000, "R4 start pulse ch12");
    @(negedge clk);
    chk(start_o, 64'h0, "R4 start pulse one cycle");
    wr(8'h1C, 32'h0050_0000, 4'b0100);
    chk(start_o, 64'h0, "R9 out-of-range start ignored");
    // R10 done
    pulse(2, 64'h1 << 33, 16'h0);
    rd_chk(8'h38, 32'h2, "R10 done ch33");
    rd_chk(8'h3C, 32'h0, "R10 done low word");
    wr(8'h1C, 32'h2100_0000, 4'b1000);
    rd_chk(8'h38, 32'h0, "R10 clear done ch33");
    // R11 control
    wr(8'h00, 32'hFFFF_FFFF, 4'b1111);
    rd_chk(8'h00, 32'h8000_000C, "R11 control writable bits");
    chk({61'b0, dyn_clk_o, rr_grp_o, rr_ch_o}, 64'h7, "R11 control outputs");
    wr(8'h00, 32'h0, 4'b0001);
    rd_chk(8'h00, 32'h8000_0000, "R11 control byte strobe");
    // R12 request status sampling
    @(negedge clk); hreq = 64'hDEAD_BEEF_0123_4567;
    rd_chk(8'h34, 32'h0123_4567, "R12 hreq low word");
    rd_chk(8'h30, 32'hDEAD_BEEF, "R12 hreq high word");
    // R3 clear
    wr(8'h18, 32'h0200_0000, 4'b1000);
    rd_chk(8'h14, 32'h8, "R3 clear eie ch2");
    // random phase, compared against the model every cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      wr_en   = ($urandom % 3) == 0;
      wr_addr = 8'(($urandom % 16) * 4);
      wr_strb = 4'($urandom);
      if (wr_addr == 8'h18 || wr_addr == 8'h1C)
        wr_data = {8'($urandom % 72), 8'($urandom % 72), 8'($urandom % 72), 8'($urandom % 72)};
      else
        wr_data = $urandom;
      rd_en   = ($urandom % 2) == 0;
      rd_addr = 8'(($urandom % 16) * 4);
      int_evt  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      err_evt  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      done_evt = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      err_cause = 16'($urandom);
      hreq = {$urandom, $urandom};
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; int_evt = '0; err_evt = '0; done_evt = '0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule